// File: doc/BRIEF.md
# Single-Port Operand Read Sequencer

This block sits in one issue slot of an out-of-order core and fetches an issued instruction's source operands through a single register-file read port. Each issue carries two source indices, a flag per source saying whether that source is used, and an optional destination tag. A used source whose producer issued in the cycle just before (from this slot or from any peer slot) is assumed to come from the bypass network and needs no read. Every other used source is read from the register array. The rule is conservative: any producer further back counts as a register read.

Instructions that need at most one read go straight through: the read happens in the cycle after issue and the operands are presented one cycle later. An instruction that needs two reads holds the port for two consecutive cycles, source A first and then source B. In its issue cycle the block flags the slower path so the scheduler can delay dependent wakeup by a cycle. During the first of its two read cycles it raises a busy signal, and the selector must not grant the slot. When both sources name the same register, one read serves both. The register array and the bypass data path are outside the block. The array is modelled as a combinational read: the data for the address driven in a cycle returns in that same cycle.

Top module: `regReadSeq`

## Requirements
- R1: After reset, rdEn, opValid and slotBusy are low, and no destination is recorded, so a source issued right after reset that names tag 0 still needs a read.
- R2: An accepted issue in cycle T that needs zero or one register read raises rdEn in T+1 only if it needs a read, with rdAddr equal to issueSrcA when A needs the read and issueSrcB when only B does. opValid is high for one cycle in T+2.
- R3: An accepted issue in cycle T that needs two reads drives rdEn in T+1 with rdAddr = issueSrcA and in T+2 with rdAddr = issueSrcB. opValid rises in T+3 with opA equal to the T+1 read data and opB equal to the T+2 read data.
- R4: slowPath is high in the issue cycle exactly when the issue is accepted and needs two separate reads.
- R5: slotBusy is high in the cycle after a two-read issue and in no other cycle. An issueValid raised while slotBusy is high is ignored: it causes no read, no opValid pulse and no destination record.
- R6: A used source whose index equals a destination tag recorded in the previous cycle needs no read. A tag is recorded when an accepted issue has issueDstValid set, or when peerValid[i] is set for peer tag i (bits i*TAG_W upward of peerTag).
- R7: A used source whose producer issued two or more cycles earlier needs a register read.
- R8: When both sources are used, both need a read and their indices are equal, a single read is made and opA and opB both carry its data.
- R9: At opValid, an operand that was not read from the register file (unused or bypassed) is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | An instruction is offered to the slot this cycle |
| issueSrcA | input | TAG_W | Register index of source A |
| issueSrcB | input | TAG_W | Register index of source B |
| issueUseA | input | 1 | Source A is present |
| issueUseB | input | 1 | Source B is present |
| issueDstValid | input | 1 | The instruction writes a destination |
| issueDst | input | TAG_W | Destination tag |
| peerValid | input | NUM_PEERS | Peer slot i issued with a destination this cycle |
| peerTag | input | NUM_PEERS*TAG_W | Destination tags of the peer slots, packed |
| rdData | input | DATA_W | Data returned by the read port for rdAddr |
| slowPath | output | 1 | The issue accepted this cycle takes the two-read path |
| slotBusy | output | 1 | The selector must not grant this slot this cycle |
| rdEn | output | 1 | Read port enable |
| rdAddr | output | TAG_W | Read port address |
| opValid | output | 1 | Operand pair valid, one-cycle pulse |
| opA | output | DATA_W | Operand A read data |
| opB | output | DATA_W | Operand B read data |

## Verification
The assertions assume that the issue inputs carry defined values whenever issueValid is high, and that reset is held at start-up before any issue is offered. They place no constraint on when issueValid may rise: issues offered while the slot is busy are legal stimulus and must be dropped. The stimulus always drives known values. It draws source and destination indices from a small range so that bypass hits, stale producers and duplicate sources occur often, and it deliberately offers issues during busy cycles.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } seqPhase_e;

  // Strobes from the control to the operand datapath
  typedef struct packed {
    logic rdEn;   // drive the read port this cycle
    logic selB;   // address source B instead of source A
    logic first;  // first read cycle of an instruction
    logic loadA;  // capture read data into operand A
    logic loadB;  // capture read data into operand B
    logic done;   // operands complete at the end of this cycle
  } seqStrobe_t;

endpackage

// File: rtl/bypassTracker.sv
module bypassTracker #(
  parameter int TAG_W     = 5,
  parameter int NUM_PEERS = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       ownValid,
  input  logic [TAG_W-1:0]           ownTag,
  input  logic [NUM_PEERS-1:0]       peerValid,
  input  logic [NUM_PEERS*TAG_W-1:0] peerTag,
  input  logic [TAG_W-1:0]           qryA,
  input  logic [TAG_W-1:0]           qryB,
  output logic                       hitA,
  output logic                       hitB
);

  localparam int NREC = NUM_PEERS + 1;

  logic [NREC-1:0] matchA;
  logic [NREC-1:0] matchB;

  // One record per destination source: entry 0 is this slot, the rest are peers.
  for (genvar i = 0; i < NREC; i++) begin : g_rec
    logic             inV;
    logic [TAG_W-1:0] inT;
    logic             recV;
    logic [TAG_W-1:0] recT;

    if (i == 0) begin : g_own
      assign inV = ownValid;
      assign inT = ownTag;
    end else begin : g_peer
      assign inV = peerValid[i-1];
      assign inT = peerTag[(i-1)*TAG_W +: TAG_W];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        recV <= 1'b0;
        recT <= '0;
      end else begin
        recV <= inV;
        recT <= inT;
      end
    end

    assign matchA[i] = recV && (recT == qryA);
    assign matchB[i] = recV && (recT == qryB);
  end

  assign hitA = |matchA;
  assign hitB = |matchB;

endmodule

// File: rtl/seqCtrl.sv
module seqCtrl
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       accept,
  input  logic       rdA,
  input  logic       rdB,
  input  logic       dup,
  output seqStrobe_t strobe,
  output logic       slotBusy
);

  seqPhase_e phase;
  logic      qA;
  logic      qB;
  logic      qDup;
  logic      twoReads;

  assign twoReads = qA && qB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      qA    <= 1'b0;
      qB    <= 1'b0;
      qDup  <= 1'b0;
    end else begin
      if (accept) begin
        phase <= PH_FIRST;
        qA    <= rdA;
        qB    <= rdB;
        qDup  <= dup;
      end else if (phase == PH_FIRST && twoReads) begin
        phase <= PH_SECOND;
      end else begin
        phase <= PH_IDLE;
      end
    end
  end

  always_comb begin
    strobe = '0;
    case (phase)
      PH_FIRST: begin
        strobe.first = 1'b1;
        strobe.rdEn  = qA || qB;
        strobe.selB  = !qA;
        strobe.loadA = qA;
        strobe.loadB = (qB && !qA) || qDup;
        strobe.done  = !twoReads;
      end
      PH_SECOND: begin
        strobe.rdEn  = 1'b1;
        strobe.selB  = 1'b1;
        strobe.loadB = 1'b1;
        strobe.done  = 1'b1;
      end
      default: strobe = '0;
    endcase
  end

  assign slotBusy = (phase == PH_FIRST) && twoReads;

endmodule

// File: rtl/seqData.sv
module seqData
  import seq_pkg::*;
#(
  parameter int TAG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accept,
  input  logic [TAG_W-1:0]  srcA,
  input  logic [TAG_W-1:0]  srcB,
  input  seqStrobe_t        strobe,
  input  logic [DATA_W-1:0] rdData,
  output logic [TAG_W-1:0]  rdAddr,
  output logic [DATA_W-1:0] opA,
  output logic [DATA_W-1:0] opB,
  output logic              opValid
);

  logic [TAG_W-1:0] aReg;
  logic [TAG_W-1:0] bReg;

  assign rdAddr = strobe.selB ? bReg : aReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aReg    <= '0;
      bReg    <= '0;
      opA     <= '0;
      opB     <= '0;
      opValid <= 1'b0;
    end else begin
      if (accept) begin
        aReg <= srcA;
        bReg <= srcB;
      end
      opValid <= strobe.done;
      if (strobe.first) begin
        opA <= strobe.loadA ? rdData : '0;
        opB <= strobe.loadB ? rdData : '0;
      end else if (strobe.loadB) begin
        opB <= rdData;
      end
    end
  end

endmodule

// File: rtl/regReadSeq.sv
module regReadSeq
  import seq_pkg::*;
#(
  parameter int  NUM_REGS  = 32,
  parameter int  DATA_W    = 32,
  parameter int  NUM_PEERS = 2,
  localparam int TAG_W     = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       issueValid,
  input  logic [TAG_W-1:0]           issueSrcA,
  input  logic [TAG_W-1:0]           issueSrcB,
  input  logic                       issueUseA,
  input  logic                       issueUseB,
  input  logic                       issueDstValid,
  input  logic [TAG_W-1:0]           issueDst,
  input  logic [NUM_PEERS-1:0]       peerValid,
  input  logic [NUM_PEERS*TAG_W-1:0] peerTag,
  input  logic [DATA_W-1:0]          rdData,
  output logic                       slowPath,
  output logic                       slotBusy,
  output logic                       rdEn,
  output logic [TAG_W-1:0]           rdAddr,
  output logic                       opValid,
  output logic [DATA_W-1:0]          opA,
  output logic [DATA_W-1:0]          opB
);

  seqStrobe_t strobe;
  logic accept;
  logic hitA;
  logic hitB;
  logic needA;
  logic needB;
  logic dup;
  logic rdB;

  assign accept = issueValid && !slotBusy;
  assign needA  = issueUseA && !hitA;
  assign needB  = issueUseB && !hitB;
  assign dup    = needA && needB && (issueSrcA == issueSrcB);
  assign rdB    = needB && !dup;
  assign slowPath = accept && needA && rdB;
  assign rdEn   = strobe.rdEn;

  bypassTracker #(.TAG_W(TAG_W), .NUM_PEERS(NUM_PEERS)) u_track (
    .clk      (clk),
    .rstN     (rstN),
    .ownValid (accept && issueDstValid),
    .ownTag   (issueDst),
    .peerValid(peerValid),
    .peerTag  (peerTag),
    .qryA     (issueSrcA),
    .qryB     (issueSrcB),
    .hitA     (hitA),
    .hitB     (hitB)
  );

  seqCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .accept  (accept),
    .rdA     (needA),
    .rdB     (rdB),
    .dup     (dup),
    .strobe  (strobe),
    .slotBusy(slotBusy)
  );

  seqData #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .accept (accept),
    .srcA   (issueSrcA),
    .srcB   (issueSrcB),
    .strobe (strobe),
    .rdData (rdData),
    .rdAddr (rdAddr),
    .opA    (opA),
    .opB    (opB),
    .opValid(opValid)
  );

endmodule

// File: rtl/seqChecker.sv
module seqChecker (
  input logic clk,
  input logic rstN,
  input logic issueValid,
  input logic issueUseA,
  input logic issueUseB,
  input logic slowPath,
  input logic slotBusy,
  input logic rdEn,
  input logic opValid
);

  // R4 / R5: a two-read issue makes the slot busy in the following cycle
  p_slow_then_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    slowPath |=> slotBusy);

  // R5: busy lasts a single cycle and the port is in use during it and after it
  p_busy_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    slotBusy |=> (!slotBusy && rdEn));

  // R3: the first read of a two-read instruction uses the port
  p_busy_reads_r3: assert property (@(posedge clk) disable iff (!rstN)
    slotBusy |-> rdEn);

  // R3: no operand pulse in the second read cycle
  p_no_early_valid_r3: assert property (@(posedge clk) disable iff (!rstN)
    slotBusy |=> !opValid);

  // R3: two-read issue completes three cycles later
  p_slow_latency_r3: assert property (@(posedge clk) disable iff (!rstN)
    slowPath |-> ##3 opValid);

  // R2: accepted issue on the fast path completes two cycles later
  p_fast_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !slotBusy && !slowPath) |-> ##2 opValid);

  // R2: an issue without sources does not touch the port
  p_no_src_no_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !slotBusy && !issueUseA && !issueUseB) |=> !rdEn);

endmodule

bind regReadSeq seqChecker u_seqChecker (
  .clk       (clk),
  .rstN      (rstN),
  .issueValid(issueValid),
  .issueUseA (issueUseA),
  .issueUseB (issueUseB),
  .slowPath  (slowPath),
  .slotBusy  (slotBusy),
  .rdEn      (rdEn),
  .opValid   (opValid)
);

// File: tb/regReadSeq_test.sv
module regReadSeq_test;

  localparam int NUM_REGS  = 32;
  localparam int DATA_W    = 32;
  localparam int NUM_PEERS = 2;
  localparam int TAG_W     = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic issueValid = 1'b0;
  logic [TAG_W-1:0] issueSrcA = '0;
  logic [TAG_W-1:0] issueSrcB = '0;
  logic issueUseA = 1'b0;
  logic issueUseB = 1'b0;
  logic issueDstValid = 1'b0;
  logic [TAG_W-1:0] issueDst = '0;
  logic [NUM_PEERS-1:0] peerValid = '0;
  logic [NUM_PEERS*TAG_W-1:0] peerTag = '0;
  logic [DATA_W-1:0] rdData;
  logic slowPath, slotBusy, rdEn, opValid;
  logic [TAG_W-1:0] rdAddr;
  logic [DATA_W-1:0] opA, opB;

  always #5 clk = ~clk;

  function automatic logic [DATA_W-1:0] regVal(input logic [TAG_W-1:0] a);
    return 32'h8000_0000 | ({27'd0, a} * 32'h0002_0103) | 32'h1;
  endfunction

  assign rdData = regVal(rdAddr);

  regReadSeq #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NUM_PEERS(NUM_PEERS)) uut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueSrcA(issueSrcA),
    .issueSrcB(issueSrcB), .issueUseA(issueUseA), .issueUseB(issueUseB),
    .issueDstValid(issueDstValid), .issueDst(issueDst), .peerValid(peerValid),
    .peerTag(peerTag), .rdData(rdData), .slowPath(slowPath), .slotBusy(slotBusy),
    .rdEn(rdEn), .rdAddr(rdAddr), .opValid(opValid), .opA(opA), .opB(opB)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;

  // expectation ring indexed by cycle
  bit               eRd[8];
  logic [TAG_W-1:0] eAddr[8];
  bit               eVal[8];
  logic [DATA_W-1:0] eA[8];
  logic [DATA_W-1:0] eB[8];
  bit               eBusy[8];
  string            eTag[8];

  // model of destinations recorded in the previous cycle (own + peers)
  bit               pV[NUM_PEERS+1];
  logic [TAG_W-1:0] pT[NUM_PEERS+1];

  task automatic chk(input string tag, input string what, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic bit inPrev(input logic [TAG_W-1:0] t);
    for (int i = 0; i < NUM_PEERS + 1; i++)
      if (pV[i] && pT[i] == t) return 1'b1;
    return 1'b0;
  endfunction

  task automatic step(input bit v, input logic [TAG_W-1:0] a, input logic [TAG_W-1:0] b,
                      input bit ua, input bit ub, input bit dv, input logic [TAG_W-1:0] d,
                      input bit [1:0] pv, input logic [TAG_W-1:0] p0,
                      input logic [TAG_W-1:0] p1, input string tag);
    int s;
    int s1, s2, s3;
    bit busyNow, acc, nA, nB, dupl, two;
    string t;
    s  = cyc % 8;
    s1 = (cyc + 1) % 8;
    s2 = (cyc + 2) % 8;
    s3 = (cyc + 3) % 8;
    @(negedge clk);
    // registered outputs for this cycle
    chk("R5", "slotBusy", {31'd0, slotBusy}, {31'd0, eBusy[s]});
    chk(eTag[s], "rdEn", {31'd0, rdEn}, {31'd0, eRd[s]});
    if (eRd[s]) chk(eTag[s], "rdAddr", {27'd0, rdAddr}, {27'd0, eAddr[s]});
    chk(eTag[s], "opValid", {31'd0, opValid}, {31'd0, eVal[s]});
    if (eVal[s]) begin
      chk((eA[s] == '0) ? "R9" : eTag[s], "opA", opA, eA[s]);
      chk((eB[s] == '0) ? "R9" : eTag[s], "opB", opB, eB[s]);
    end
    busyNow = eBusy[s];
    eRd[s] = 0; eVal[s] = 0; eBusy[s] = 0; eTag[s] = "R2";
    // drive this cycle's inputs
    issueValid = v; issueSrcA = a; issueSrcB = b; issueUseA = ua; issueUseB = ub;
    issueDstValid = dv; issueDst = d; peerValid = pv; peerTag = {p1, p0};
    #1;
    acc  = v && !busyNow;
    nA   = ua && !inPrev(a);
    nB   = ub && !inPrev(b);
    dupl = nA && nB && (a == b);
    two  = nA && nB && !dupl;
    chk("R4", "slowPath", {31'd0, slowPath}, {31'd0, acc && two});
    t = (tag != "") ? tag : (two ? "R3" : "R2");
    if (v && busyNow) eTag[s1] = "R5";
    if (acc) begin
      if (two) begin
        eBusy[s1] = 1; eRd[s1] = 1; eAddr[s1] = a; eTag[s1] = t;
        eRd[s2] = 1; eAddr[s2] = b; eTag[s2] = t;
        eVal[s3] = 1; eA[s3] = regVal(a); eB[s3] = regVal(b); eTag[s3] = t;
      end else begin
        eRd[s1] = nA || nB; eAddr[s1] = nA ? a : b; eTag[s1] = t;
        eVal[s2] = 1; eA[s2] = nA ? regVal(a) : '0; eB[s2] = nB ? regVal(b) : '0;
        eTag[s2] = t;
      end
    end
    pV[0] = acc && dv; pT[0] = d;
    pV[1] = pv[0]; pT[1] = p0;
    pV[2] = pv[1]; pT[2] = p1;
    cyc++;
  endtask

  task automatic issue(input logic [TAG_W-1:0] a, input logic [TAG_W-1:0] b, input bit ua,
                       input bit ub, input bit dv, input logic [TAG_W-1:0] d, input string tag);
    step(1, a, b, ua, ub, dv, d, 2'b00, 0, 0, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 2'b00, 0, 0, "");
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      eRd[i] = 0; eVal[i] = 0; eBusy[i] = 0; eTag[i] = "R1";
      eAddr[i] = '0; eA[i] = '0; eB[i] = '0;
    end
    for (int i = 0; i < NUM_PEERS + 1; i++) begin pV[i] = 0; pT[i] = '0; end
    void'($urandom(32'd24681));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state at the ports
    chk("R1", "rdEn after reset", {31'd0, rdEn}, 32'd0);
    chk("R1", "opValid after reset", {31'd0, opValid}, 32'd0);
    chk("R1", "slotBusy after reset", {31'd0, slotBusy}, 32'd0);
    idle(1);
    issue(0, 0, 1, 0, 0, 0, "R1");      // tag 0 must still be read after reset
    idle(3);
    issue(3, 0, 1, 0, 0, 0, "R2");      // A only
    idle(3);
    issue(0, 9, 0, 1, 0, 0, "R2");      // B only, address must be srcB
    idle(3);
    issue(0, 0, 0, 0, 1, 2, "R2");      // no sources
    idle(3);
    issue(4, 5, 1, 1, 0, 0, "R3");      // two reads
    idle(4);
    issue(0, 0, 0, 0, 1, 10, "R6");     // producer
    issue(10, 11, 1, 1, 0, 0, "R6");    // A bypassed, B read
    idle(3);
    step(0, 0, 0, 0, 0, 0, 0, 2'b10, 0, 12, "R6");  // peer 1 issues tag 12
    issue(7, 12, 1, 1, 0, 0, "R6");     // B bypassed from peer, A read
    idle(3);
    step(0, 0, 0, 0, 0, 0, 0, 2'b01, 15, 0, "R6");  // peer 0 issues tag 15
    issue(15, 15, 1, 1, 0, 0, "R9");    // both bypassed: no read, zero operands
    idle(3);
    issue(0, 0, 0, 0, 1, 13, "R7");     // producer
    idle(1);
    issue(13, 14, 1, 1, 0, 0, "R7");    // stale producer: two reads
    idle(4);
    issue(6, 6, 1, 1, 0, 0, "R8");      // duplicate source: one read
    idle(3);
    issue(16, 17, 1, 1, 0, 0, "R5");    // two reads
    issue(20, 21, 1, 1, 1, 22, "R5");   // offered while busy: ignored
    issue(22, 0, 1, 0, 0, 0, "R5");     // tag 22 must not be recorded: read needed
    idle(4);
    issue(1, 2, 1, 1, 0, 0, "R3");      // back-to-back after a two-read
    idle(1);
    issue(8, 0, 1, 0, 0, 0, "R2");      // issued in the second read cycle
    issue(9, 0, 1, 0, 0, 0, "R2");
    idle(4);
    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 4) != 0, TAG_W'($urandom % 8), TAG_W'($urandom % 8),
           $urandom % 2, $urandom % 2, $urandom % 2, TAG_W'($urandom % 8),
           2'($urandom % 4), TAG_W'($urandom % 8), TAG_W'($urandom % 8), "");
    end
    idle(5);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule